// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block lets a clocked host read and write a 128K x 8 static RAM that has no clock of its own. The host makes a request with a write flag, a 17-bit word address and a write byte. It holds the request until a one-cycle ready pulse comes back. For a read, the byte is then on the read data output. On the memory side the controller drives two chip enables of opposite polarity, an active-low output enable, an active-low write enable and the address. The data bus is split into an outgoing byte, an incoming byte and a driver enable, which an outer tri-state pad joins together.

Every analogue interval of the memory becomes a whole number of clock cycles: ceil(ns / clock period), and never less than one. The nanosecond values come from one speed-grade parameter (15, 20 or 25). For a write, the address and data are set one cycle before the write strobe falls and are held one cycle after it rises. The strobe stays low long enough to cover the pulse width, the data setup time and the full cycle time. For a read, the chip is deselected after the data is sampled, and the controller then waits out the memory's output float time before the transaction ends. A write that follows therefore never meets a driven bus.

The controller is a state machine with seven states:
- IDLE: all pins inactive.
- RD_ACCESS: chip selected and output enabled for the read cycle count.
- RD_RELEASE: chip deselected for the float count.
- WR_SETUP: one cycle with address and data driven and the strobe high.
- WR_PULSE: the write strobe is low.
- WR_HOLD: one cycle with the strobe high and the data still driven.
- DONE: ready is high.

The transitions are as follows:
- IDLE goes to RD_ACCESS or WR_SETUP when a request arrives.
- RD_ACCESS goes to RD_RELEASE when its counter expires.
- RD_RELEASE goes to DONE when its counter expires.
- WR_SETUP goes to WR_PULSE after one cycle.
- WR_PULSE goes to WR_HOLD when its counter expires.
- WR_HOLD goes to DONE after one cycle.
- DONE goes to IDLE after one cycle.

Top module: `asram_ctrl`

## Requirements
- R1: During and right after reset, the pins sit at these levels: ce1_n=1, ce2=0, oe_n=1, we_n=1, dq_oe=0 and host_ready=0.
- R2: The memory is selected only when ce1_n=0 and ce2=1. The two enables always switch together (ce1_n equals the inverse of ce2), and the chip is selected only inside a transaction.
- R3: A read returns the byte stored at the 17-bit address. The data is sampled after RC cycles of selection with oe_n low. host_ready rises RC+HZ+1 rising edges after the edge that accepts the request.
- R4: we_n is low only while the chip is selected, oe_n is high and dq_oe is 1. It stays low for exactly P = max(WP, DS, RC-2, 1) cycles. host_ready rises P+3 edges after the accepting edge.
- R5: The address and write data are stable for one full cycle before we_n falls and for one cycle after it rises.
- R6: dq_oe is 0 whenever oe_n is 0. After oe_n rises, dq_oe stays 0 for at least HZ cycles.
- R7: host_ready is high for exactly one cycle per transaction. host_rdata keeps the last read byte until the next read completes.
- R8: The controller ignores changes to host_req, host_we, host_addr and host_wdata from the accepting edge until it is back in IDLE.
- R9: Each cycle count equals ceil(ns / CLK_PERIOD_NS), with a minimum of 1, where:
  - RC is the read/write cycle time: 15, 20 or 25 ns.
  - WP is the write pulse width: 12, 15 or 20 ns.
  - DS is the data setup time: 8, 10 or 15 ns.
  - HZ is the output float time: 7, 8 or 10 ns.
  - The value in each list is picked by SPEED_GRADE_NS (15, 20 or 25, in that order).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Request, held until host_ready |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 17 | Word address |
| host_wdata | input | 8 | Byte to write |
| host_ready | output | 1 | One-cycle completion pulse |
| host_rdata | output | 8 | Last byte read |
| sram_addr | output | 17 | Memory address |
| sram_ce1_n | output | 1 | Active-low chip enable |
| sram_ce2 | output | 1 | Active-high chip enable |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_we_n | output | 1 | Active-low write strobe |
| sram_dq_o | output | 8 | Byte driven toward the memory |
| sram_dq_i | input | 8 | Byte coming from the memory |
| sram_dq_oe | output | 1 | Controller drives the data bus |

## Verification
At the default grade of 20 with a 4 ns clock, RC=5, HZ=2 and P=4. A read's ready pulse is therefore due 8 rising edges after the accepting edge, and a write's is due 7. The bench computes these counts from the nanosecond lists by its own ceiling function. It counts rising edges from the accepting edge and samples ready, read data and pins at the falling edge, half a cycle after the registers update. A memory model in the bench samples the pins at every falling edge. It times the write strobe, the setup and hold stability and the float window against the same counts. One falling edge after each ready pulse, it confirms that ready has dropped.

// File: rtl/asram_ctl_pkg.sv
package asram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_RD_RELEASE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_DONE
    } ctl_state_t;

    localparam int KIND_CYCLE = 0;
    localparam int KIND_PULSE = 1;
    localparam int KIND_SETUP = 2;
    localparam int KIND_FLOAT = 3;

    // nanosecond figure for one interval kind of one speed grade
    function automatic int grade_ns(input int grade, input int kind);
        int v;
        case (grade)
            15: v = (kind == KIND_CYCLE) ? 15 : (kind == KIND_PULSE) ? 12 :
                    (kind == KIND_SETUP) ? 8  : 7;
            20: v = (kind == KIND_CYCLE) ? 20 : (kind == KIND_PULSE) ? 15 :
                    (kind == KIND_SETUP) ? 10 : 8;
            default: v = (kind == KIND_CYCLE) ? 25 : (kind == KIND_PULSE) ? 20 :
                    (kind == KIND_SETUP) ? 15 : 10;
        endcase
        return v;
    endfunction

    // ceiling division with a floor of one cycle
    function automatic int ns_to_cycles(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/asram_cyc_timer.sv
module asram_cyc_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/asram_bus_regs.sv
module asram_bus_regs #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [DATA_W-1:0] h_wdata,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] rd_byte
);

    // address and write byte are frozen for the whole transaction
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else if (accept) begin
            mem_addr  <= h_addr;
            mem_wdata <= h_wdata;
        end
    end

    // read byte is kept until the next read samples the bus
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_byte <= '0;
        end else if (capture) begin
            rd_byte <= dq_in;
        end
    end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_ctl_pkg::*;
#(
    parameter int SPEED_GRADE_NS = 20,
    parameter int CLK_PERIOD_NS  = 4,
    parameter int ADDR_W         = 17,
    parameter int DATA_W         = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ready,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce1_n,
    output logic              sram_ce2,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [DATA_W-1:0] sram_dq_o,
    input  logic [DATA_W-1:0] sram_dq_i,
    output logic              sram_dq_oe
);

    localparam int RC_CYC = ns_to_cycles(grade_ns(SPEED_GRADE_NS, KIND_CYCLE), CLK_PERIOD_NS);
    localparam int WP_CYC = ns_to_cycles(grade_ns(SPEED_GRADE_NS, KIND_PULSE), CLK_PERIOD_NS);
    localparam int DS_CYC = ns_to_cycles(grade_ns(SPEED_GRADE_NS, KIND_SETUP), CLK_PERIOD_NS);
    localparam int HZ_CYC = ns_to_cycles(grade_ns(SPEED_GRADE_NS, KIND_FLOAT), CLK_PERIOD_NS);
    localparam int P_A    = (WP_CYC > DS_CYC) ? WP_CYC : DS_CYC;
    localparam int P_B    = (RC_CYC - 2 > 1) ? RC_CYC - 2 : 1;
    localparam int PULSE_CYC = (P_A > P_B) ? P_A : P_B;
    localparam int MAX_A  = (RC_CYC > PULSE_CYC) ? RC_CYC : PULSE_CYC;
    localparam int CNT_MAX = (MAX_A > HZ_CYC) ? MAX_A : HZ_CYC;
    localparam int CNT_W  = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] RC_LD = CNT_W'(RC_CYC - 1);
    localparam logic [CNT_W-1:0] HZ_LD = CNT_W'(HZ_CYC - 1);
    localparam logic [CNT_W-1:0] WP_LD = CNT_W'(PULSE_CYC - 1);

    ctl_state_t       state, nxt;
    logic             tmr_expired;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             accept;
    logic             capture;

    assign accept  = (state == ST_IDLE) && host_req;
    assign capture = (state == ST_RD_ACCESS) && tmr_expired;

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:       if (host_req) nxt = host_we ? ST_WR_SETUP : ST_RD_ACCESS;
            ST_RD_ACCESS:  if (tmr_expired) nxt = ST_RD_RELEASE;
            ST_RD_RELEASE: if (tmr_expired) nxt = ST_DONE;
            ST_WR_SETUP:   nxt = ST_WR_PULSE;
            ST_WR_PULSE:   if (tmr_expired) nxt = ST_WR_HOLD;
            ST_WR_HOLD:    nxt = ST_DONE;
            ST_DONE:       nxt = ST_IDLE;
            default:       nxt = ST_IDLE;
        endcase
    end

    // timer reload on every state entry
    always_comb begin
        tmr_load = (nxt != state);
        unique case (nxt)
            ST_RD_ACCESS:  tmr_val = RC_LD;
            ST_RD_RELEASE: tmr_val = HZ_LD;
            ST_WR_PULSE:   tmr_val = WP_LD;
            default:       tmr_val = '0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // pin register, decoded from the next state so pins never glitch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sram_ce1_n <= 1'b1;
            sram_ce2   <= 1'b0;
            sram_oe_n  <= 1'b1;
            sram_we_n  <= 1'b1;
            sram_dq_oe <= 1'b0;
            host_ready <= 1'b0;
        end else begin
            sram_ce1_n <= !(nxt inside {ST_RD_ACCESS, ST_WR_SETUP, ST_WR_PULSE});
            sram_ce2   <=  (nxt inside {ST_RD_ACCESS, ST_WR_SETUP, ST_WR_PULSE});
            sram_oe_n  <= !(nxt == ST_RD_ACCESS);
            sram_we_n  <= !(nxt == ST_WR_PULSE);
            sram_dq_oe <=  (nxt inside {ST_WR_SETUP, ST_WR_PULSE, ST_WR_HOLD});
            host_ready <=  (nxt == ST_DONE);
        end
    end

    asram_cyc_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    asram_bus_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .h_addr    (host_addr),
        .h_wdata   (host_wdata),
        .capture   (capture),
        .dq_in     (sram_dq_i),
        .mem_addr  (sram_addr),
        .mem_wdata (sram_dq_o),
        .rd_byte   (host_rdata)
    );

    // cycles since the memory output enable was last low, saturating
    logic [CNT_W-1:0] float_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               float_cnt <= CNT_W'(HZ_CYC);
        else if (!sram_oe_n)                      float_cnt <= '0;
        else if (float_cnt < CNT_W'(HZ_CYC))      float_cnt <= float_cnt + 1'b1;
    end

    AST_ENABLE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        sram_ce1_n == !sram_ce2); // R2
    AST_WE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (!sram_ce1_n && sram_ce2 && sram_oe_n && sram_dq_oe)); // R4
    AST_SETUP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_we_n) |-> ($stable(sram_addr) && $stable(sram_dq_o))); // R5
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> ($stable(sram_addr) && $stable(sram_dq_o))); // R5
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> !sram_dq_oe); // R6
    AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_dq_oe) |-> (float_cnt >= CNT_W'(HZ_CYC))); // R6
    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |=> !host_ready); // R7

endmodule

// File: tb/tb_asram_ctrl.sv
module tb_asram_ctrl;

    localparam int GRADE  = 20;
    localparam int PERIOD = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [16:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_ready;
    logic [7:0]  host_rdata;
    logic [16:0] sram_addr;
    logic        sram_ce1_n, sram_ce2, sram_oe_n, sram_we_n, sram_dq_oe;
    logic [7:0]  sram_dq_o;
    logic [7:0]  sram_dq_i;

    int n_vec = 0;
    int n_bad = 0;

    always #(PERIOD/2) clk = ~clk;

    asram_ctrl #(.SPEED_GRADE_NS(GRADE), .CLK_PERIOD_NS(PERIOD)) dut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
        .host_rdata(host_rdata), .sram_addr(sram_addr), .sram_ce1_n(sram_ce1_n),
        .sram_ce2(sram_ce2), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
        .sram_dq_o(sram_dq_o), .sram_dq_i(sram_dq_i), .sram_dq_oe(sram_dq_oe)
    );

    // expected cycle counts from the requirement figures (R9)
    function automatic int cyc(input int ns);
        int c;
        c = (ns + PERIOD - 1) / PERIOD;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int pick(input int a15, input int a20, input int a25);
        return (GRADE == 15) ? a15 : (GRADE == 20) ? a20 : a25;
    endfunction
    localparam int E_RC = cyc(pick(15, 20, 25));
    localparam int E_WP = cyc(pick(12, 15, 20));
    localparam int E_DS = cyc(pick(8, 10, 15));
    localparam int E_HZ = cyc(pick(7, 8, 10));
    function automatic int pulse_len();
        int p;
        p = (E_WP > E_DS) ? E_WP : E_DS;
        if (E_RC - 2 > p) p = E_RC - 2;
        return (p < 1) ? 1 : p;
    endfunction

    function automatic logic [7:0] blank_val(input logic [16:0] a);
        return a[7:0] ^ a[15:8] ^ {7'h1E, a[16]};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // memory model
    logic [7:0] mem_arr [int];
    logic [7:0] ref_mem [int];

    always @(sram_addr or sram_ce1_n or sram_ce2 or sram_oe_n or sram_we_n or n_vec) begin
        if (!sram_ce1_n && sram_ce2 && !sram_oe_n && sram_we_n)
            sram_dq_i = mem_arr.exists(int'(sram_addr)) ? mem_arr[int'(sram_addr)]
                                                      : blank_val(sram_addr);
        else
            sram_dq_i = 8'hEE;
    end

    int          float_left = 0;
    int          low_cnt = 0;
    logic        prev_we = 1'b1;
    logic        prev_oe_drv = 1'b0;
    logic [16:0] prev_addr = '0;
    logic [7:0]  prev_dq = '0;
    bit          hold_pend = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            bit sel;
            bit drv;
            sel = !sram_ce1_n && sram_ce2;
            drv = sel && !sram_oe_n && sram_we_n;
            if (sram_ce1_n != !sram_ce2)
                chk(1'b0, "R2 enable pair", sram_ce1_n, !sram_ce2);
            if (sram_dq_oe && (drv || float_left > 0))
                chk(1'b0, "R6 contention", float_left, 0);
            if (drv) float_left = E_HZ;
            else if (float_left > 0) float_left--;
            if (hold_pend) begin
                chk(sram_addr == prev_addr && sram_dq_o == prev_dq, "R5 hold", sram_addr, prev_addr);
                hold_pend = 1'b0;
            end
            if (!sram_we_n) begin
                if (!sel || !sram_oe_n || !sram_dq_oe)
                    chk(1'b0, "R4 strobe context", sel, 1);
                if (prev_we)
                    chk(prev_oe_drv && sram_addr == prev_addr && sram_dq_o == prev_dq,
                        "R5 setup", sram_addr, prev_addr);
                mem_arr[int'(sram_addr)] = sram_dq_o;
                low_cnt++;
            end else if (low_cnt > 0) begin
                chk(low_cnt == pulse_len(), "R4 pulse width", low_cnt, pulse_len());
                low_cnt = 0;
                hold_pend = 1'b1;
            end
            prev_we = sram_we_n;
            prev_oe_drv = sram_dq_oe;
            prev_addr = sram_addr;
            prev_dq = sram_dq_o;
        end
    end

    logic [7:0] last_rd = 8'h00;

    task automatic do_op(input bit wr, input logic [16:0] a, input logic [7:0] d,
                         input bit disturb);
        int n;
        int exp_lat;
        logic [7:0] exp_rd;
        exp_rd  = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : blank_val(a);
        exp_lat = wr ? pulse_len() + 3 : E_RC + E_HZ + 1;
        @(negedge clk);
        host_req = 1'b1; host_we = wr; host_addr = a; host_wdata = d;
        n = 0;
        forever begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (disturb && n == 2) begin
                host_addr = a ^ 17'h1; host_wdata = ~d; host_we = !wr;
            end
            if (host_ready || n > 64) break;
        end
        if (wr) chk(n == exp_lat, "R4 R9 write latency", n, exp_lat);
        else    chk(n == exp_lat, "R3 R9 read latency", n, exp_lat);
        if (wr) begin
            ref_mem[int'(a)] = d;
            chk(host_rdata == last_rd, "R7 rdata held over write", host_rdata, last_rd);
        end else begin
            chk(host_rdata == exp_rd, disturb ? "R8 R3 read data" : "R3 read data",
                host_rdata, exp_rd);
            last_rd = exp_rd;
        end
        host_req = 1'b0;
        @(negedge clk);
        chk(!host_ready, "R7 single ready", host_ready, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [16:0] pool [8];
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        chk({sram_ce1_n, sram_ce2, sram_oe_n, sram_we_n, sram_dq_oe, host_ready} == 6'b101100,
            "R1 reset pins", {sram_ce1_n, sram_ce2, sram_oe_n, sram_we_n, sram_dq_oe, host_ready},
            6'b101100);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({sram_ce1_n, sram_ce2, sram_oe_n, sram_we_n, sram_dq_oe, host_ready} == 6'b101100,
            "R1 idle pins", {sram_ce1_n, sram_ce2, sram_oe_n, sram_we_n, sram_dq_oe, host_ready},
            6'b101100);

        // directed corners
        do_op(1'b1, 17'h00000, 8'h11, 1'b0);
        do_op(1'b1, 17'h1FFFF, 8'hEF, 1'b0);
        do_op(1'b0, 17'h00000, 8'h00, 1'b0);
        do_op(1'b0, 17'h1FFFF, 8'h00, 1'b0);
        do_op(1'b0, 17'h0A5A5, 8'h00, 1'b0);          // never written
        do_op(1'b1, 17'h0A5A5, 8'h3C, 1'b0);          // write right after read
        do_op(1'b0, 17'h0A5A5, 8'h00, 1'b0);
        do_op(1'b0, 17'h00100, 8'h77, 1'b1);          // R8: disturbed read
        do_op(1'b0, 17'h00101, 8'h00, 1'b0);          // neighbour must be untouched
        do_op(1'b1, 17'h00200, 8'h5A, 1'b1);          // R8: disturbed write
        do_op(1'b0, 17'h00200, 8'h00, 1'b0);
        do_op(1'b0, 17'h00201, 8'h00, 1'b0);

        for (int i = 0; i < 8; i++) pool[i] = 17'($urandom);
        for (int i = 0; i < 120; i++) begin
            logic [16:0] a;
            a = ($urandom_range(0, 1) == 0) ? pool[$urandom_range(0, 7)] : 17'($urandom);
            do_op(1'($urandom), a, 8'($urandom), ($urandom_range(0, 7) == 0));
            repeat ($urandom_range(0, 2)) @(negedge clk);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule